// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A single countdown timer that a host drives through a small synchronous register bus. The host sets a reload value, picks a counting mode (free-running, periodic or one-shot), a counter size of 16 or 32 bits, and a prescale of 1, 16 or 256 applied to an external timer clock enable. The host can read the live count back at any time. Each time the count reaches zero, a raw interrupt flag is set. An enable bit masks that flag onto an interrupt line, and a write to a dedicated index clears it.

A second reload register, the background reload, changes the value used at the next reload and leaves the running count alone. Writing the ordinary reload register also loads the counter at once. In free-running mode the timer wraps to the all-ones value of the selected size rather than to the programmed value.

Top module: `pdc_timer`

## Requirements
- R1: Registers are selected by word index on `bus_addr`: 0 reload (read/write), 1 live count (read only), 2 control, 3 interrupt clear (write only), 4 raw flag, 5 masked flag, 6 background reload. Reading index 0 or 6 returns the stored reload value. Reading any other index returns zero.
- R2: Control bits: 0 one-shot, 1 wide (32-bit) count, 3:2 prescale select, 5 interrupt enable, 6 periodic, 7 run. Bits 7:0 read back as written and bits 31:8 read as zero. After reset the control register reads 0x20, and the count, the reload value and the raw flag read zero.
- R3: A write to index 0 places the written word in the counter at that same clock edge. This write takes priority over a decrement or a reload in that cycle.
- R4: The count changes only on a prescaled tick, and a tick needs both the run bit and `tick_en`. With `tick_en` low, or the run bit clear, the count holds.
- R5: Prescale select 00 and 11 give one tick per `tick_en` pulse. Select 01 gives one tick per 16 pulses and 10 one tick per 256 pulses. The prescaler restarts from zero whenever the run bit is clear, so the first tick after enabling comes exactly one full division later.
- R6: A tick that takes the count from 1 to 0 sets the raw flag. In periodic mode (bit 6 set), the next tick at zero loads the stored reload value.
- R7: In free-running mode (bits 6 and 0 both clear), the tick at zero loads all ones: 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R8: In one-shot mode (bit 0 set, bit 6 clear), the count stays at zero and raises no further interrupt until index 0 is written.
- R9: In 16-bit mode only the low 16 bits of the count take part in counting. The count reads back zero-extended, while the reload registers read back the full stored word.
- R10: A write to index 6 stores the reload value without changing the count. The new value is used at the next reload.
- R11: The masked flag (index 5) and `irq` equal the raw flag ANDed with control bit 5.
- R12: Any write to index 3 clears the raw flag. If an expiry falls in the same cycle, the flag stays set.
- R13: Writes to index 1, and to indices 7 and above, change no register, count or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timer clock enable, one pulse per timer time step |
| bus_addr | input | ADDR_W | Word index of the register accessed |
| bus_we | input | 1 | Write strobe for the indexed register |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt line: raw flag AND interrupt enable |

## Verification
The bench builds the block with its default parameters: a 32-bit counter with a 16-bit narrow mode, prescale shifts of 4 and 8, and a 4-bit word index. These widths put the divide-by-256 path within a few hundred cycles. Starting from a small reload value, the 32-bit and 16-bit free-running wraps each show up after a single expiry. Indices 7 to 15 are left free, so reads and writes to undefined addresses can be exercised.

// File: rtl/pdc_timer_pkg.sv
package pdc_timer_pkg;

  // register word indices; software decodes these
  localparam int unsigned IDX_RELOAD = 0;
  localparam int unsigned IDX_COUNT  = 1;
  localparam int unsigned IDX_CTRL   = 2;
  localparam int unsigned IDX_ICLR   = 3;
  localparam int unsigned IDX_RAW    = 4;
  localparam int unsigned IDX_MASKED = 5;
  localparam int unsigned IDX_BGLOAD = 6;

  localparam int unsigned CTRL_W     = 8;
  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  // control layout, MSB first
  typedef struct packed {
    logic       run;
    logic       periodic;
    logic       irq_en;
    logic       spare;
    logic [1:0] div_sel;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  // free-running when neither periodic nor one-shot is chosen
  function automatic logic is_free(ctrl_t c);
    return !c.periodic && !c.oneshot;
  endfunction

endpackage

// File: rtl/pdc_timer_prescale.sv
module pdc_timer_prescale #(
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick_en,
  input  logic [1:0] div_sel,
  output logic       ptick
);
  localparam int unsigned PW = HI_LOG2;

  logic [PW-1:0] pcnt_q;

  // low bits that must be all ones for a tick
  function automatic logic [PW-1:0] div_mask(logic [1:0] sel);
    case (sel)
      2'b01:   return PW'((1 << MID_LOG2) - 1);
      2'b10:   return {PW{1'b1}};
      default: return '0;
    endcase
  endfunction

  logic [PW-1:0] mask;
  assign mask  = div_mask(div_sel);
  assign ptick = run && tick_en && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt_q <= '0;
    else if (tick_en)   pcnt_q <= pcnt_q + PW'(1);
  end

endmodule

// File: rtl/pdc_timer_counter.sv
module pdc_timer_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptick,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             wide,
  input  logic             oneshot,
  output logic [CNT_W-1:0] cnt_raw,
  output logic [CNT_W-1:0] count_vis,
  output logic             expire
);
  function automatic logic [CNT_W-1:0] width_mask(logic w);
    return w ? {CNT_W{1'b1}} : {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cur;
  logic             at_zero, at_one;

  assign cur       = cnt_q & width_mask(wide);
  assign at_zero   = (cur == '0);
  assign at_one    = (cur == CNT_W'(1));
  assign expire    = ptick && at_one;
  assign cnt_raw   = cnt_q;
  assign count_vis = cur;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load_wr)     cnt_q <= load_data;
    else if (ptick) begin
      if (!at_zero)       cnt_q <= cur - CNT_W'(1);
      else if (!oneshot)  cnt_q <= reload_val;
    end
  end

endmodule

// File: rtl/pdc_timer_regs.sv
module pdc_timer_regs
  import pdc_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic [CNT_W-1:0]  count_vis,
  input  logic              expire,
  output logic              run,
  output logic              wide,
  output logic              oneshot,
  output logic              free_mode,
  output logic              irq_en,
  output logic [1:0]        div_sel,
  output logic [CNT_W-1:0]  reload_q,
  output logic              load_wr,
  output logic              bgload_wr,
  output logic              clr_wr,
  output logic              raw_flag,
  output logic              irq,
  output logic [CNT_W-1:0]  bus_rdata
);
  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned idx);
    return a == ADDR_W'(idx);
  endfunction

  ctrl_t ctrl_q;
  logic  ctrl_wr;
  logic  masked;

  assign load_wr   = bus_we && hit(bus_addr, IDX_RELOAD);
  assign bgload_wr = bus_we && hit(bus_addr, IDX_BGLOAD);
  assign ctrl_wr   = bus_we && hit(bus_addr, IDX_CTRL);
  assign clr_wr    = bus_we && hit(bus_addr, IDX_ICLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= ctrl_t'(CTRL_RESET);
      reload_q <= '0;
      raw_flag <= 1'b0;
    end else begin
      if (ctrl_wr)               ctrl_q   <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (load_wr || bgload_wr)  reload_q <= bus_wdata;
      if (expire)                raw_flag <= 1'b1;
      else if (clr_wr)           raw_flag <= 1'b0;
    end
  end

  assign run       = ctrl_q.run;
  assign wide      = ctrl_q.wide;
  assign oneshot   = ctrl_q.oneshot && !ctrl_q.periodic;
  assign free_mode = is_free(ctrl_q);
  assign irq_en    = ctrl_q.irq_en;
  assign div_sel   = ctrl_q.div_sel;
  assign masked    = raw_flag && ctrl_q.irq_en;
  assign irq       = masked;

  always_comb begin
    bus_rdata = '0;
    if (hit(bus_addr, IDX_RELOAD) || hit(bus_addr, IDX_BGLOAD)) bus_rdata = reload_q;
    else if (hit(bus_addr, IDX_COUNT))  bus_rdata = count_vis;
    else if (hit(bus_addr, IDX_CTRL))   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
    else if (hit(bus_addr, IDX_RAW))    bus_rdata = CNT_W'(raw_flag);
    else if (hit(bus_addr, IDX_MASKED)) bus_rdata = CNT_W'(masked);
  end

endmodule

// File: rtl/pdc_timer.sv
module pdc_timer #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  // named internal events, also watched by the checker
  logic             run, wide, oneshot, free_mode, irq_en;
  logic [1:0]       div_sel;
  logic [CNT_W-1:0] reload_q, reload_val, cnt_raw, count_vis;
  logic             load_wr, bgload_wr, clr_wr, raw_flag;
  logic             ptick, expire;

  function automatic logic [CNT_W-1:0] pick_reload(logic free, logic [CNT_W-1:0] stored);
    return free ? {CNT_W{1'b1}} : stored;
  endfunction

  assign reload_val = pick_reload(free_mode, reload_q);

  pdc_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .count_vis(count_vis), .expire(expire),
    .run(run), .wide(wide), .oneshot(oneshot), .free_mode(free_mode),
    .irq_en(irq_en), .div_sel(div_sel), .reload_q(reload_q),
    .load_wr(load_wr), .bgload_wr(bgload_wr), .clr_wr(clr_wr),
    .raw_flag(raw_flag), .irq(irq), .bus_rdata(bus_rdata)
  );

  pdc_timer_prescale #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_en(tick_en),
    .div_sel(div_sel), .ptick(ptick)
  );

  pdc_timer_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ptick(ptick), .load_wr(load_wr),
    .load_data(bus_wdata), .reload_val(reload_val), .wide(wide),
    .oneshot(oneshot), .cnt_raw(cnt_raw), .count_vis(count_vis),
    .expire(expire)
  );

endmodule

// File: rtl/pdc_timer_chk.sv
module pdc_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             run,
  input logic [1:0]       div_sel,
  input logic             ptick,
  input logic             expire,
  input logic             load_wr,
  input logic             bgload_wr,
  input logic             clr_wr,
  input logic             raw_flag,
  input logic             irq,
  input logic             irq_en,
  input logic             oneshot,
  input logic [CNT_W-1:0] cnt_raw,
  input logic [CNT_W-1:0] count_vis,
  input logic [CNT_W-1:0] bus_wdata
);

  assert_load_immediate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> cnt_raw == $past(bus_wdata));

  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptick && !load_wr) |=> $stable(cnt_raw));

  assert_div1_every_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && (div_sel == 2'b00 || div_sel == 2'b11)) |-> ptick);

  assert_expire_sets_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> raw_flag);

  assert_oneshot_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptick && oneshot && count_vis == '0 && !load_wr) |=> $stable(cnt_raw) && !expire);

  assert_bgload_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bgload_wr && !ptick) |=> $stable(cnt_raw));

  assert_irq_rise_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(expire) || $rose(irq_en)));

  assert_clear_drops_raw_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !raw_flag);

endmodule

bind pdc_timer pdc_timer_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(run), .div_sel(div_sel),
  .ptick(ptick), .expire(expire), .load_wr(load_wr), .bgload_wr(bgload_wr),
  .clr_wr(clr_wr), .raw_flag(raw_flag), .irq(irq), .irq_en(irq_en),
  .oneshot(oneshot), .cnt_raw(cnt_raw), .count_vis(count_vis),
  .bus_wdata(bus_wdata)
);

// File: tb/test_pdc_timer.sv
`timescale 1ns/1ps
module test_pdc_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  localparam int A_RELOAD = 0, A_COUNT = 1, A_CTRL = 2, A_ICLR = 3,
                 A_RAW = 4, A_MASKED = 5, A_BGLOAD = 6;

  always #5 clk = ~clk;

  pdc_timer i_pdc_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // all tasks start and end just after a falling edge
  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    bus_addr = idx[3:0]; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    bus_addr = idx[3:0];
    #1;
    v = bus_rdata;
  endtask

  task automatic expect_reg(input string tag, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    check(tag, $sformatf("reg[%0d]", idx), v, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0; tick_en = 1'b1; bus_we = 1'b0;
    cyc(2);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset();
    expect_reg("R2", A_CTRL, 32'h20);
    expect_reg("R2", A_COUNT, 32'h0);
    expect_reg("R2", A_RELOAD, 32'h0);
    expect_reg("R2", A_RAW, 32'h0);
    expect_reg("R11", A_MASKED, 32'h0);
    check("R11", "irq", irq, 1'b0);
    wr(A_CTRL, 32'hFFFF_FFFF);
    expect_reg("R2", A_CTRL, 32'hFF);
  endtask

  task automatic t_periodic;
    do_reset();
    wr(A_RELOAD, 5);
    wr(A_CTRL, 32'hE2);
    expect_reg("R2", A_CTRL, 32'hE2);
    cyc(3);
    expect_reg("R4", A_COUNT, 2);
    cyc(2);
    expect_reg("R6", A_COUNT, 0);
    expect_reg("R6", A_RAW, 1);
    expect_reg("R11", A_MASKED, 1);
    check("R11", "irq", irq, 1'b1);
    cyc(1);
    expect_reg("R6", A_COUNT, 5);
  endtask

  task automatic t_mask_and_clear;
    do_reset();
    wr(A_RELOAD, 2);
    wr(A_CTRL, 32'hC2);
    cyc(2);
    expect_reg("R11", A_RAW, 1);
    expect_reg("R11", A_MASKED, 0);
    check("R11", "irq masked off", irq, 1'b0);
    wr(A_ICLR, 0);
    expect_reg("R12", A_RAW, 0);
    // clear landing on an expiry
    do_reset();
    wr(A_RELOAD, 2);
    wr(A_CTRL, 32'hE2);
    cyc(1);
    wr(A_ICLR, 32'h1234);
    expect_reg("R12", A_RAW, 1);
    cyc(1);
    wr(A_ICLR, 0);
    expect_reg("R12", A_RAW, 0);
    check("R12", "irq after clear", irq, 1'b0);
  endtask

  task automatic t_oneshot;
    do_reset();
    wr(A_RELOAD, 3);
    wr(A_CTRL, 32'hA3);
    cyc(3);
    expect_reg("R8", A_COUNT, 0);
    expect_reg("R8", A_RAW, 1);
    wr(A_ICLR, 0);
    cyc(10);
    expect_reg("R8", A_COUNT, 0);
    expect_reg("R8", A_RAW, 0);
  endtask

  task automatic t_free_running;
    do_reset();
    wr(A_RELOAD, 2);
    wr(A_CTRL, 32'hA0);
    cyc(2);
    expect_reg("R7", A_COUNT, 0);
    cyc(1);
    expect_reg("R7", A_COUNT, 32'hFFFF);
    cyc(1);
    expect_reg("R7", A_COUNT, 32'hFFFE);
    do_reset();
    wr(A_RELOAD, 1);
    wr(A_CTRL, 32'hA2);
    cyc(1);
    expect_reg("R7", A_COUNT, 0);
    cyc(1);
    expect_reg("R7", A_COUNT, 32'hFFFF_FFFF);
  endtask

  task automatic t_narrow;
    do_reset();
    wr(A_RELOAD, 32'h0012_3456);
    expect_reg("R9", A_COUNT, 32'h3456);
    expect_reg("R9", A_RELOAD, 32'h0012_3456);
    expect_reg("R1", A_BGLOAD, 32'h0012_3456);
    wr(A_CTRL, 32'h22);
    expect_reg("R9", A_COUNT, 32'h0012_3456);
    do_reset();
    wr(A_RELOAD, 32'h0001_0002);
    wr(A_CTRL, 32'hE0);
    cyc(2);
    expect_reg("R9", A_COUNT, 0);
    expect_reg("R9", A_RAW, 1);
    cyc(1);
    expect_reg("R9", A_COUNT, 2);
  endtask

  task automatic t_background;
    do_reset();
    wr(A_RELOAD, 4);
    wr(A_CTRL, 32'hE2);
    wr(A_BGLOAD, 10);
    expect_reg("R10", A_COUNT, 3);
    expect_reg("R1", A_RELOAD, 10);
    expect_reg("R1", A_BGLOAD, 10);
    cyc(3);
    expect_reg("R10", A_COUNT, 0);
    cyc(1);
    expect_reg("R10", A_COUNT, 10);
  endtask

  task automatic t_ignored;
    do_reset();
    wr(A_RELOAD, 7);
    wr(A_COUNT, 32'h55);
    expect_reg("R13", A_COUNT, 7);
    wr(9, 32'hFFFF_FFFF);
    wr(15, 32'hFFFF_FFFF);
    expect_reg("R13", A_CTRL, 32'h20);
    expect_reg("R13", A_RELOAD, 7);
    expect_reg("R13", A_COUNT, 7);
    expect_reg("R13", A_RAW, 0);
    expect_reg("R1", 7, 0);
    expect_reg("R1", 15, 0);
    expect_reg("R1", A_ICLR, 0);
  endtask

  task automatic t_prescale;
    do_reset();
    wr(A_RELOAD, 2);
    wr(A_CTRL, 32'hE6);
    cyc(15);
    expect_reg("R5", A_COUNT, 2);
    cyc(1);
    expect_reg("R5", A_COUNT, 1);
    cyc(16);
    expect_reg("R5", A_COUNT, 0);
    expect_reg("R5", A_RAW, 1);
    do_reset();
    wr(A_RELOAD, 1);
    wr(A_CTRL, 32'hEA);
    cyc(255);
    expect_reg("R5", A_COUNT, 1);
    cyc(1);
    expect_reg("R5", A_COUNT, 0);
    do_reset();
    wr(A_RELOAD, 3);
    wr(A_CTRL, 32'hEE);
    cyc(1);
    expect_reg("R5", A_COUNT, 2);
    // prescaler restarts after a pause
    do_reset();
    wr(A_RELOAD, 5);
    wr(A_CTRL, 32'hE6);
    cyc(10);
    wr(A_CTRL, 32'h66);
    cyc(3);
    wr(A_CTRL, 32'hE6);
    cyc(15);
    expect_reg("R5", A_COUNT, 5);
    cyc(1);
    expect_reg("R5", A_COUNT, 4);
  endtask

  task automatic t_gating_and_load;
    do_reset();
    wr(A_RELOAD, 5);
    tick_en = 1'b0;
    wr(A_CTRL, 32'hE2);
    cyc(10);
    expect_reg("R4", A_COUNT, 5);
    tick_en = 1'b1;
    cyc(2);
    expect_reg("R4", A_COUNT, 3);
    wr(A_CTRL, 32'h62);
    cyc(4);
    expect_reg("R4", A_COUNT, 2);
    do_reset();
    wr(A_RELOAD, 5);
    wr(A_CTRL, 32'hE2);
    cyc(2);
    expect_reg("R3", A_COUNT, 3);
    wr(A_RELOAD, 9);
    expect_reg("R3", A_COUNT, 9);
    cyc(1);
    expect_reg("R3", A_COUNT, 8);
  endtask

  initial begin
    @(negedge clk);
    t_reset_state();
    t_periodic();
    t_mask_and_clear();
    t_oneshot();
    t_free_running();
    t_narrow();
    t_background();
    t_ignored();
    t_prescale();
    t_gating_and_load();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule